// File: doc/BRIEF.md
# Streaming RGB to YUV Colour-Space Converter

This block turns a stream of unsigned 8-bit red, green and blue samples into luma (Y) and two chroma bytes (U, V). Every channel is a weighted sum of the three inputs. The weights are signed integers with 15 fractional bits. The sum is scaled down by an arithmetic right shift, and the chroma channels then receive a mid-scale bias of 128.

The input side and the output side each use a valid/ready handshake. Three register stages separate them: products, sum, and scale/bias/clamp. When the consumer holds back, all three stages freeze together. A new pixel can enter on every cycle in which the output is free to advance.

Top module: `rgb_yuv_conv`

## Requirements
- R1: Y equals floor((9798·R + 19235·G + 3736·B) / 2^15), clamped to 0..255.
- R2: U equals floor((4221·B − 4784·R − 9437·G) / 2^15) + 128, clamped to 0..255. For any 8-bit input, U therefore lies in 17..160.
- R3: V equals floor((20218·R − 16941·G − 3277·B) / 2^15) + 128, clamped to 0..255.
- R4: The scaling is an arithmetic shift, so a negative sum rounds toward minus infinity. White (255,255,255) gives Y=255, U=50, V=128.
- R5: A result above 255 saturates to 255 and a result below 0 saturates to 0. (255,0,0) gives V=255 and (0,255,255) gives V=0.
- R6: With the output ready, a pixel accepted on a clock edge appears with out_valid exactly three edges later. Every accepted pixel comes out once, in order.
- R7: While out_valid is high and out_ready is low, the outputs hold their values and in_ready is low.
- R8: After reset, out_valid is low and in_ready is high.
- R9: Black (0,0,0) yields Y=0, U=128, V=128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the pixel on this edge |
| in_r | input | PIX_W | Red sample, unsigned |
| in_g | input | PIX_W | Green sample, unsigned |
| in_b | input | PIX_W | Blue sample, unsigned |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output on this edge |
| out_y | output | PIX_W | Luma byte |
| out_u | output | PIX_W | Blue-difference chroma byte |
| out_v | output | PIX_W | Red-difference chroma byte |

## Verification
The bench builds the block with its defaults: 8-bit samples, a 15-bit fraction and a 26-bit signed accumulator. These values cover the whole input cube. The V channel saturates at both ends of the range and the U channel floors from negative sums, so the clamp and the shift direction are both observable. Some pixels pass through an otherwise idle pipeline, so their latency can be counted exactly. A long random stream under random backpressure tests the freeze, the ordering and the holding of values.

// File: rtl/rgb_yuv_pkg.sv
package rgb_yuv_pkg;

    localparam int NUM_CH = 3;

    // Channel order: 0 = luma, 1 = blue difference, 2 = red difference.
    // Term order: 0 = red, 1 = green, 2 = blue. Weights are scaled by 2^15.
    function automatic int coef(input int ch, input int term);
        int w;
        case (ch)
            0:       w = (term == 0) ? 9798  : (term == 1) ? 19235  : 3736;
            1:       w = (term == 0) ? -4784 : (term == 1) ? -9437  : 4221;
            default: w = (term == 0) ? 20218 : (term == 1) ? -16941 : -3277;
        endcase
        return w;
    endfunction

    function automatic int bias(input int ch);
        return (ch == 0) ? 0 : 128;
    endfunction

endpackage

// File: rtl/yuv_valid_pipe.sv
module yuv_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic in_v,
    output logic out_v
);
    logic [DEPTH-1:0] v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (en) v_d = {v_q[DEPTH-2:0], in_v};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign out_v = v_q[DEPTH-1];
endmodule

// File: rtl/yuv_lane.sv
module yuv_lane #(
    parameter int PIX_W = 8,
    parameter int FRAC  = 15,
    parameter int ACC_W = 26,
    parameter int K0    = 0,
    parameter int K1    = 0,
    parameter int K2    = 0,
    parameter int BIAS  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    input  logic [PIX_W-1:0] c,
    output logic [PIX_W-1:0] res
);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic [ACC_W-1:0] p0;
        logic [ACC_W-1:0] p1;
        logic [ACC_W-1:0] p2;
        logic [ACC_W-1:0] sum;
        logic [PIX_W-1:0] res;
    } lane_t;

    lane_t st_d, st_q;

    function automatic logic [ACC_W-1:0] mul(input logic [PIX_W-1:0] x, input int k);
        logic signed [ACC_W-1:0] xs;
        logic signed [ACC_W-1:0] ks;
        xs = $signed({{(ACC_W-PIX_W){1'b0}}, x});
        ks = ACC_W'(k);
        return xs * ks;
    endfunction

    function automatic logic [PIX_W-1:0] finish(input logic [ACC_W-1:0] s);
        logic signed [ACC_W-1:0] t;
        t = ($signed(s) >>> FRAC) + ACC_W'(BIAS);
        if (t[ACC_W-1])  return '0;
        else if (t > MAXV) return MAXV[PIX_W-1:0];
        else              return t[PIX_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.p0  = mul(a, K0);
            st_d.p1  = mul(b, K1);
            st_d.p2  = mul(c, K2);
            st_d.sum = st_q.p0 + st_q.p1 + st_q.p2;
            st_d.res = finish(st_q.sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res = st_q.res;
endmodule

// File: rtl/rgb_yuv_conv.sv
module rgb_yuv_conv #(
    parameter int PIX_W = 8,
    parameter int FRAC  = 15,
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_u,
    output logic [PIX_W-1:0] out_v
);
    import rgb_yuv_pkg::*;

    localparam int STAGES = 3;

    logic             adv;
    logic [PIX_W-1:0] lane_res [NUM_CH];

    assign adv      = out_ready || !out_valid;
    assign in_ready = adv;

    yuv_valid_pipe #(.DEPTH(STAGES)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .in_v  (in_valid),
        .out_v (out_valid)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        yuv_lane #(
            .PIX_W (PIX_W),
            .FRAC  (FRAC),
            .ACC_W (ACC_W),
            .K0    (coef(ch, 0)),
            .K1    (coef(ch, 1)),
            .K2    (coef(ch, 2)),
            .BIAS  (bias(ch))
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (adv),
            .a     (in_r),
            .b     (in_g),
            .c     (in_b),
            .res   (lane_res[ch])
        );
    end

    assign out_y = lane_res[0];
    assign out_u = lane_res[1];
    assign out_v = lane_res[2];
endmodule

// File: rtl/rgb_yuv_conv_chk.sv
module rgb_yuv_conv_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_u,
    input logic [PIX_W-1:0] out_v
);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_y) && $stable(out_u) && $stable(out_v)));

    assert_no_intake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1))
            |-> out_valid);

    assert_u_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_u >= PIX_W'(17) && out_u <= PIX_W'(160)));
endmodule

bind rgb_yuv_conv rgb_yuv_conv_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_y     (out_y),
    .out_u     (out_u),
    .out_v     (out_v)
);

// File: tb/tb_rgb_yuv_conv.sv
`timescale 1ns/1ps
module tb_rgb_yuv_conv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_y, out_u, out_v;

    always #4 clk = ~clk;

    rgb_yuv_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    typedef struct {
        int    y, u, v;
        int    acc_cyc;
        bit    lat;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   stall_mode = 0;
    bit   held = 0;
    int   hy, hu, hv;

    always @(posedge clk) cyc++;

    function automatic int ref_val(int ch, int r, int g, int b);
        int s, q;
        case (ch)
            0: s = 9798 * r + 19235 * g + 3736 * b;
            1: s = -4784 * r - 9437 * g + 4221 * b;
            default: s = 20218 * r - 16941 * g - 3277 * b;
        endcase
        q = (s >>> 15) + ((ch == 0) ? 0 : 128);
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic drive(int r, int g, int b, bit lat, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        e.y = ref_val(0, r, g, b);
        e.u = ref_val(1, r, g, b);
        e.v = ref_val(2, r, g, b);
        e.acc_cyc = cyc;
        e.lat = lat;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor and scoreboard
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
            #1;
            if (held) begin
                check("R7 valid held", int'(out_valid), 1);
                check("R7 Y held", int'(out_y), hy);
                check("R7 U held", int'(out_u), hu);
                check("R7 V held", int'(out_v), hv);
            end
            if (out_valid && !out_ready) begin
                check("R7 in_ready low", int'(in_ready), 0);
                hy = out_y; hu = out_u; hv = out_v;
                held = 1;
            end else begin
                held = 0;
            end
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    check("R6 unexpected output", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag == "" ? "R1" : e.tag, " Y"}, int'(out_y), e.y);
                    check({e.tag == "" ? "R2" : e.tag, " U"}, int'(out_u), e.u);
                    check({e.tag == "" ? "R3" : e.tag, " V"}, int'(out_v), e.v);
                    if (e.lat) check("R6 latency", cyc - e.acc_cyc, 3);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 out_valid after reset", int'(out_valid), 0);
        check("R8 in_ready after reset", int'(in_ready), 1);

        // Isolated pixels through an idle pipeline
        drive(0, 0, 0, 1, "R9");       idle(4);
        drive(255, 255, 255, 1, "R4"); idle(4);
        drive(255, 0, 0, 1, "R5");     idle(4);
        drive(0, 255, 255, 1, "R5");   idle(4);
        drive(0, 0, 255, 1, "R2");     idle(4);
        drive(255, 255, 0, 1, "R2");   idle(4);
        drive(128, 64, 200, 1, "");    idle(4);

        // Back-to-back stream, output always ready
        for (int i = 0; i < 40; i++)
            drive($urandom % 256, $urandom % 256, $urandom % 256, 1, "");
        idle(6);

        // Random backpressure
        stall_mode = 1;
        for (int i = 0; i < 200; i++)
            drive($urandom % 256, $urandom % 256, $urandom % 256, 0, "");
        drive(0, 0, 0, 0, "R9");
        idle(2);
        for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
        stall_mode = 0;
        idle(8);
        check("R6 all pixels delivered", sb.size(), 0);
        finish_run();
    end
endmodule